// File: doc/BRIEF.md
# Clause 45 Station Management Master

This block is a station-management controller. It runs Clause 45 MII management transactions over a two-wire interface: a management clock (MDC) and a shared data line (MDIO). The host presents one request at a time with a start pulse. A request holds:

- a read/write select,
- a 5-bit PHY address,
- a 5-bit MMD number,
- a 16-bit register address,
- 16-bit write data.

The block latches the request and issues it as two frames back to back. The first is an address frame that carries the register address. The second is the read or write frame itself.

MDC comes from the system clock through a programmable divider. The master updates MDIO when MDC falls and samples the line when MDC rises. MDIO leaves the block as a data bit plus an output enable, and the line is assumed to have a pull-up to logic one. When the second frame ends, a one-cycle done pulse marks completion. For a read, the returned word is valid from that point.

Top module: `mdio45_master`

## Requirements
- R1: After reset, busy, done, mdc and mdio_oe are all low.
- R2: While busy, mdc toggles every `half_div+1` system clocks, so one MDC period is `2*(half_div+1)` clocks. MDC rests low whenever busy is low.
- R3: Each accepted request first produces an address frame of 64 MDC bits, sent in this order: 32 ones, start `00`, opcode `00`, the PHY address (MSB first), the MMD number (MSB first), turnaround `10`, then the 16-bit register address (MSB first). mdio_oe is high for every bit of this frame.
- R4: The address frame is followed at once by a second 64-bit frame with the same preamble, start field, PHY address and MMD number. Its opcode is `11` for a read (`rd_nwr`=1) and `01` for a write.
- R5: In a write frame, the master drives turnaround `10` and then the 16-bit write data MSB first, with mdio_oe high throughout.
- R6: In a read frame, mdio_oe is low from the first turnaround bit (bit index 46, counting from 0) to the end of the frame. The 16 data bits (indices 48..63) are sampled at MDC rising edges, MSB first, and appear on rd_data.
- R7: mdio_o and mdio_oe change only in the clock where MDC falls (or when a request starts). They are stable while MDC is high and at each MDC rising edge.
- R8: A start pulse while busy is high is ignored. The frames in progress keep their original fields, and no extra frames follow.
- R9: done is a single-clock pulse in the cycle after the last MDC falling edge of the second frame. busy drops in the same cycle.
- R10: While idle, mdio_oe is low, so MDIO is released to its pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_div | input | DIV_W | MDC half-period in system clocks, minus one |
| start | input | 1 | Request strobe, taken only while idle |
| rd_nwr | input | 1 | 1 selects read, 0 selects write |
| phy_addr | input | 5 | Target PHY address |
| mmd_num | input | 5 | Target MMD number |
| reg_addr | input | 16 | Register address carried by the address frame |
| wr_data | input | 16 | Data for a write |
| mdio_i | input | 1 | MDIO line as seen at the pin |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO driver enable |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Word captured by the last read |

## Verification
The hardest case to reach is the read frame, where the master must release the line and sample it. This only works if something outside answers in step with MDC. The bench models a PHY that follows MDC edges: it drives 0 in the second turnaround bit and then a chosen word, changing its output only after MDC falls. Mixing all-zero, all-one and random read words with random divider settings shows that sampling falls on the rising edge and in MSB-first order. A second start pulse injected in the middle of a transaction shows that the latched fields cannot be disturbed.

// File: rtl/mdio45_master.sv
module mdio45_master #(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic             start,
  input  logic             rd_nwr,
  input  logic [4:0]       phy_addr,
  input  logic [4:0]       mmd_num,
  input  logic [15:0]      reg_addr,
  input  logic [15:0]      wr_data,
  input  logic             mdio_i,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             busy,
  output logic             done,
  output logic [15:0]      rd_data
);

  localparam int FB = PRE_LEN + 32;
  localparam int IW = $clog2(FB);
  localparam logic [IW-1:0] LAST   = IW'(FB - 1);
  localparam logic [IW-1:0] TA_IDX = IW'(FB - 18);
  localparam logic [IW-1:0] D_IDX  = IW'(FB - 16);

  function automatic logic [FB-1:0] mk_frame(input logic [1:0] op, input logic [4:0] pa,
                                             input logic [4:0] ma, input logic [1:0] ta,
                                             input logic [15:0] fld);
    return {{PRE_LEN{1'b1}}, 2'b00, op, pa, ma, ta, fld};
  endfunction

  logic [DIV_W-1:0] cnt;
  logic [FB-1:0]    sh;
  logic [IW-1:0]    bitn;
  logic [IW-1:0]    nb;
  logic             second, rd_q;
  logic [4:0]       phy_q, mmd_q;
  logic [15:0]      addr_q, wd_q, rsh;
  logic             tick;

  assign nb   = bitn + 1'b1;
  assign tick = busy && (cnt == half_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; sh <= '0; bitn <= '0; second <= 1'b0; rd_q <= 1'b0;
      phy_q <= '0; mmd_q <= '0; addr_q <= '0; wd_q <= '0; rsh <= '0;
      mdc <= 1'b0; mdio_o <= 1'b1; mdio_oe <= 1'b0;
      busy <= 1'b0; done <= 1'b0; rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          rd_q    <= rd_nwr;
          phy_q   <= phy_addr;
          mmd_q   <= mmd_num;
          addr_q  <= reg_addr;
          wd_q    <= wr_data;
          cnt     <= '0;
          mdc     <= 1'b0;
          bitn    <= '0;
          second  <= 1'b0;
          sh      <= mk_frame(2'b00, phy_addr, mmd_num, 2'b10, reg_addr);
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b1;
        end
      end else if (tick) begin
        cnt <= '0;
        mdc <= ~mdc;
        if (!mdc) begin
          if (second && rd_q && bitn >= D_IDX)
            rsh <= {rsh[14:0], mdio_i};
        end else if (bitn == LAST) begin
          if (!second) begin
            second  <= 1'b1;
            bitn    <= '0;
            sh      <= rd_q ? mk_frame(2'b11, phy_q, mmd_q, 2'b11, 16'hFFFF)
                            : mk_frame(2'b01, phy_q, mmd_q, 2'b10, wd_q);
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b1;
          end else begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            if (rd_q) rd_data <= rsh;
          end
        end else begin
          bitn    <= nb;
          sh      <= {sh[FB-2:0], 1'b1};
          mdio_o  <= sh[FB-2];
          mdio_oe <= !(second && rd_q && nb >= TA_IDX);
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) $past(!rst_n) |-> !busy && !done && !mdc && !mdio_oe);
  p_mdc_idle_r2: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdc);
  p_addr_oe_r3: assert property (@(posedge clk) disable iff (!rst_n) busy && !second |-> mdio_oe);
  p_write_oe_r5: assert property (@(posedge clk) disable iff (!rst_n) busy && !rd_q |-> mdio_oe);
  p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && second && rd_q && bitn >= D_IDX |-> !mdio_oe);
  p_stable_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mdc && $past(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));
  p_stable_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(phy_q) && $stable(mmd_q) && $stable(addr_q) && $stable(rd_q));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && $past(busy));
  p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdio_oe);

endmodule

// File: tb/tb_mdio45_master.sv
module tb_mdio45_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] half_div = 8'd0;
  logic start = 1'b0, rd_nwr = 1'b0;
  logic [4:0] phy_addr = '0, mmd_num = '0;
  logic [15:0] reg_addr = '0, wr_data = '0;
  logic mdio_i = 1'b1;
  logic mdc, mdio_o, mdio_oe, busy, done;
  logic [15:0] rd_data;

  mdio45_master dut (.clk(clk), .rst_n(rst_n), .half_div(half_div), .start(start), .rd_nwr(rd_nwr),
    .phy_addr(phy_addr), .mmd_num(mmd_num), .reg_addr(reg_addr), .wr_data(wr_data), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy), .done(done), .rd_data(rd_data));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [63:0] cap_o [2];
  logic [63:0] cap_oe [2];
  int idx = 0, fnum = 0;
  logic prev_mdc = 1'b0, held = 1'b0, held_oe = 1'b0;
  int last_rise = -1, per_err = 0, stab_err = 0;
  logic rd_txn = 1'b0;
  logic [15:0] phy_word = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] pa,
                                            input logic [4:0] ma, input logic [1:0] ta,
                                            input logic [15:0] f);
    return {32'hFFFF_FFFF, 2'b00, op, pa, ma, ta, f};
  endfunction

  always @(negedge clk) begin
    if (mdc && !prev_mdc) begin
      if (last_rise >= 0 && (cyc - last_rise) != 2 * (int'(half_div) + 1)) per_err++;
      last_rise = cyc;
      held = mdio_o; held_oe = mdio_oe;
      if (fnum < 2) begin
        cap_o[fnum][63-idx] = mdio_o;
        cap_oe[fnum][63-idx] = mdio_oe;
      end
      idx++;
      if (idx == 64) begin idx = 0; fnum++; end
    end else if (mdc && (mdio_o !== held || mdio_oe !== held_oe)) begin
      stab_err++;
    end
    if (!mdc && prev_mdc) begin
      if (fnum == 1 && rd_txn && idx == 47) mdio_i = 1'b0;
      else if (fnum == 1 && rd_txn && idx >= 48) mdio_i = phy_word[15-(idx-48)];
      else mdio_i = 1'b1;
    end
    prev_mdc = mdc;
  end

  task automatic run(input logic rd, input logic [4:0] pa, input logic [4:0] ma,
                     input logic [15:0] ra, input logic [15:0] wd, input logic [15:0] pw,
                     input logic [7:0] dv, input bit poke);
    logic [63:0] e1, m1;
    int done_cnt;
    half_div = dv; rd_txn = rd; phy_word = pw;
    fnum = 0; idx = 0; per_err = 0; stab_err = 0; last_rise = -1;
    cap_o[0] = '0; cap_o[1] = '0; cap_oe[0] = '0; cap_oe[1] = '0;
    @(negedge clk);
    rd_nwr = rd; phy_addr = pa; mmd_num = ma; reg_addr = ra; wr_data = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      rd_nwr = ~rd; phy_addr = ~pa; mmd_num = ~ma; reg_addr = ~ra; wr_data = ~wd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    done_cnt = 0;
    chk(!busy, "R9", "busy with done", 64'(busy), 64'd0);
    @(negedge clk);
    chk(!done, "R9", "done width", 64'(done), 64'd0);
    chk(!mdio_oe && !mdc, "R10", "idle release", {62'd0, mdc, mdio_oe}, 64'd0);
    chk(fnum == 2 && idx == 0, "R4", "frame count", 64'(fnum), 64'd2);
    chk(cap_o[0] == exp_frame(2'b00, pa, ma, 2'b10, ra), "R3", "address frame",
        cap_o[0], exp_frame(2'b00, pa, ma, 2'b10, ra));
    chk(cap_oe[0] == '1, "R3", "address frame enable", cap_oe[0], '1);
    if (rd) begin
      m1 = {{46{1'b1}}, 18'd0};
      e1 = exp_frame(2'b11, pa, ma, 2'b11, 16'hFFFF) & m1;
      chk((cap_o[1] & m1) == e1, "R4", "read frame header", cap_o[1] & m1, e1);
      chk(cap_oe[1] == m1, "R6", "read release", cap_oe[1], m1);
      chk(rd_data == pw, "R6", "read data", 64'(rd_data), 64'(pw));
    end else begin
      e1 = exp_frame(2'b01, pa, ma, 2'b10, wd);
      chk(cap_o[1] == e1, "R5", "write frame", cap_o[1], e1);
      chk(cap_oe[1] == '1, "R5", "write enable", cap_oe[1], '1);
    end
    chk(per_err == 0, "R2", "mdc period errors", 64'(per_err), 64'd0);
    chk(stab_err == 0, "R7", "mdio change while mdc high", 64'(stab_err), 64'd0);
    if (poke) chk(fnum == 2 && cap_o[0] == exp_frame(2'b00, pa, ma, 2'b10, ra), "R8",
                  "start while busy ignored", 64'(fnum), 64'd2);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mdc && !mdio_oe, "R1", "reset state",
        {60'd0, busy, done, mdc, mdio_oe}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mdio_oe, "R10", "idle after reset", 64'(mdio_oe), 64'd0);
    run(1'b0, 5'd31, 5'd0, 16'h8001, 16'hA5A5, 16'h0, 8'd0, 1'b0);
    run(1'b1, 5'd0, 5'd31, 16'hFFFF, 16'h0, 16'h0000, 8'd1, 1'b0);
    run(1'b1, 5'd5, 5'd3, 16'h0000, 16'h0, 16'hFFFF, 8'd0, 1'b0);
    run(1'b1, 5'd9, 5'd1, 16'h1234, 16'h0, 16'h8001, 8'd2, 1'b1);
    run(1'b0, 5'd17, 5'd7, 16'h4321, 16'h5A5A, 16'h0, 8'd3, 1'b1);
    for (int i = 0; i < 12; i++)
      run(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
          16'($urandom), 8'($urandom_range(0, 3)), 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule